// File: doc/BRIEF.md
# IDE Control-Block Register Emulator

This block models the device side of an IDE/ATA control block at one register offset. That offset means two different things. A host write loads a write-only Device Control register. A host read returns Alternate Status, which is the 8-bit status of one of two emulated devices. The `dev_sel` input picks the device, and the block samples it in the same cycle as the read strobe.

Each device keeps its own status byte and its own interrupt-pending flag. Device logic updates the status through per-device update strobes and raises an interrupt with a one-cycle request pulse. The interrupt line to the host follows the pending flag of the selected device, gated by the interrupt-disable bit in Device Control. A read of the primary status register has its own strobe and clears the selected device's pending flag. An Alternate Status read has no such side effect.

Setting the software-reset bit does the following:
- It emits a one-clock reset pulse toward the device logic.
- It holds both devices at a busy status with their pending flags clear.
- When the bit is cleared again, both devices are released to status 00h.

Top module: `ide_ctl_emu`

## Requirements
- R1: After reset the following are all zero: `host_rdata`, `host_rvalid`, `host_irq`, `srst_pulse`, and both device status bytes. The Device Control state is also cleared, so software reset and interrupt disable are both off.
- R2: A write loads only two Device Control bits: bit 2 is software reset and bit 1 is interrupt disable. Bits 7:3 and bit 0 have no effect. Device Control cannot be read back, because a read always returns device status.
- R3: A read strobe with no write returns the status of the device chosen by `dev_sel` in that same cycle. The data appears on `host_rdata` one cycle later with `host_rvalid` high for one cycle. `dev_sel`=0 selects device 0 and `dev_sel`=1 selects device 1.
- R4: If a write and a read strobe come in the same cycle, the write takes effect and the read is dropped: `host_rvalid` stays low and no pending flag is cleared.
- R5: `dev_upd[d]` loads `dev_stat` into the status of device d on the next clock, unless software reset is active.
- R6: `dev_irq_req[d]` sets the pending flag of device d. `host_irq` equals the selected device's pending flag when interrupt disable is 0.
- R7: While interrupt disable (bit 1) is 1, `host_irq` is 0. Pending flags are kept and show again once the bit is cleared.
- R8: An Alternate Status read (`host_rd_alt`) never clears any pending flag.
- R9: A primary status read (`host_rd_pri`, which wins if both read strobes are high) returns the selected status as in R3. It clears only the selected device's pending flag.
- R10: A write that changes software reset from 0 to 1 raises `srst_pulse` for exactly one cycle, starting the cycle after the write. Writing 1 again while it is already set gives no pulse.
- R11: While software reset is set, both statuses read 80h and both pending flags are clear. Status updates and interrupt requests are ignored.
- R12: After a write clears software reset, both statuses become 00h.
- R13: An interrupt request and a primary read of the same device in one cycle leave that device's pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe to Device Control |
| host_wdata | input | 8 | Host write data |
| host_rd_alt | input | 1 | Host Alternate Status read strobe |
| host_rd_pri | input | 1 | Host primary status read strobe (clears pending) |
| dev_sel | input | 1 | Device select, 0 = device 0, 1 = device 1 |
| host_rdata | output | 8 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle per accepted read |
| host_irq | output | 1 | Interrupt to host |
| srst_pulse | output | 1 | One-clock software reset pulse to device logic |
| dev_upd | input | 2 | Per-device status load strobes |
| dev_stat | input | 8 | Status value to load |
| dev_irq_req | input | 2 | Per-device interrupt request pulses |

## Verification
The status path is swept with all 256 status values. Complementary bytes go to the two devices, so a wrong select or a crossed data lane gives a visible mismatch.

The control path is swept with all 256 write values, each starting from a pending interrupt on device 0. This separates:
- the masking bit from the reset bit;
- both of those from the reserved bits;
- whether a write leaks into the read data.

Directed sequences then check the interrupt side effects:
- primary reads against alternate reads, on the selected device and the other device;
- a request and a clear in the same cycle;
- a read and a write in the same cycle;
- the reset hold and release, including a repeated write of the reset bit.

// File: rtl/ide_ctl_pkg.sv
package ide_ctl_pkg;
  localparam int unsigned SRST_POS = 2;
  localparam int unsigned NIEN_POS = 1;

  // A read strobe counts only when no write shares the cycle.
  function automatic logic accept_rd(input logic rd, input logic wr);
    return rd & ~wr;
  endfunction

  // Interrupt visible to the host.
  function automatic logic irq_gate(input logic pend, input logic disable_bit);
    return pend & ~disable_bit;
  endfunction
endpackage

// File: rtl/ide_ctl_reg.sv
module ide_ctl_reg
  import ide_ctl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         srst,
  output logic         nien,
  output logic         srst_rise,
  output logic         srst_fall
);
  logic srst_d1;
  logic resv_nz;

  // reserved bits are observed only by the checks below
  always_comb begin
    resv_nz = 1'b0;
    for (int i = 0; i < W; i++)
      if (i != SRST_POS && i != NIEN_POS) resv_nz = resv_nz | wdata[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srst    <= 1'b0;
      nien    <= 1'b0;
      srst_d1 <= 1'b0;
    end else begin
      srst_d1 <= srst;
      if (wr_en) begin
        srst <= wdata[SRST_POS];
        nien <= wdata[NIEN_POS];
      end
    end
  end

  assign srst_rise = srst & ~srst_d1;
  assign srst_fall = ~srst & srst_d1;

  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_rise |=> !srst_rise);
  p_resv_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && resv_nz) |=> (srst == $past(wdata[SRST_POS]) && nien == $past(wdata[NIEN_POS])));
endmodule

// File: rtl/ide_dev_slot.sv
module ide_dev_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         srst_fall,
  input  logic         upd,
  input  logic [W-1:0] upd_data,
  input  logic         irq_req,
  input  logic         clr,
  output logic [W-1:0] status,
  output logic         pend
);
  localparam logic [W-1:0] BUSY = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      pend   <= 1'b0;
    end else if (srst) begin
      status <= BUSY;
      pend   <= 1'b0;
    end else begin
      if (srst_fall)  status <= '0;
      else if (upd)   status <= upd_data;
      if (irq_req)    pend <= 1'b1;
      else if (clr)   pend <= 1'b0;
    end
  end

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(srst) && srst) |-> (status == BUSY && !pend));
  p_release_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    srst_fall |=> (status == '0));
  p_req_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !srst) |=> pend);
endmodule

// File: rtl/ide_rd_port.sv
module ide_rd_port
  import ide_ctl_pkg::*;
#(
  parameter int W     = 8,
  parameter int NDEV  = 2,
  parameter int SEL_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_alt,
  input  logic              rd_pri,
  input  logic              wr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [NDEV*W-1:0] status_flat,
  output logic [W-1:0]      rdata,
  output logic              rvalid,
  output logic [NDEV-1:0]   pri_clr
);
  logic rd_acc;
  logic pri_acc;

  assign rd_acc  = accept_rd(rd_alt | rd_pri, wr);
  assign pri_acc = accept_rd(rd_pri, wr);

  for (genvar d = 0; d < NDEV; d++) begin : g_clr
    assign pri_clr[d] = pri_acc && (sel == SEL_W'(d));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_acc;
      if (rd_acc) rdata <= status_flat[sel*W +: W];
    end
  end

  p_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_alt && !wr) |=> rvalid);
  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !rvalid);
  p_clr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pri_clr));
  p_alt_noclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_pri) |-> (pri_clr == '0));
endmodule

// File: rtl/ide_ctl_emu.sv
module ide_ctl_emu
  import ide_ctl_pkg::*;
#(
  parameter int W    = 8,
  parameter int NDEV = 2,
  localparam int SEL_W = $clog2(NDEV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [W-1:0]     host_wdata,
  input  logic             host_rd_alt,
  input  logic             host_rd_pri,
  input  logic [SEL_W-1:0] dev_sel,
  output logic [W-1:0]     host_rdata,
  output logic             host_rvalid,
  output logic             host_irq,
  output logic             srst_pulse,
  input  logic [NDEV-1:0]  dev_upd,
  input  logic [W-1:0]     dev_stat,
  input  logic [NDEV-1:0]  dev_irq_req
);
  logic              srst, nien, srst_rise, srst_fall;
  logic [NDEV-1:0]   pend_vec;
  logic [NDEV-1:0]   pri_clr;
  logic [NDEV*W-1:0] status_flat;

  ide_ctl_reg #(.W(W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .wdata(host_wdata),
    .srst(srst), .nien(nien), .srst_rise(srst_rise), .srst_fall(srst_fall)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    ide_dev_slot #(.W(W)) u_slot (
      .clk(clk), .rst_n(rst_n), .srst(srst), .srst_fall(srst_fall),
      .upd(dev_upd[d]), .upd_data(dev_stat), .irq_req(dev_irq_req[d]),
      .clr(pri_clr[d]), .status(status_flat[d*W +: W]), .pend(pend_vec[d])
    );
  end

  ide_rd_port #(.W(W), .NDEV(NDEV), .SEL_W(SEL_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_alt(host_rd_alt), .rd_pri(host_rd_pri),
    .wr(host_wr), .sel(dev_sel), .status_flat(status_flat),
    .rdata(host_rdata), .rvalid(host_rvalid), .pri_clr(pri_clr)
  );

  assign host_irq   = irq_gate(pend_vec[dev_sel], nien);
  assign srst_pulse = srst_rise;

  p_nien_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(host_wr) && $past(host_wdata[NIEN_POS])) |-> !host_irq);
  p_alt_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_alt && !host_rd_pri && !srst && pend_vec[dev_sel])
      |=> pend_vec[$past(dev_sel)]);
  p_pulse_after_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |-> ($past(host_wr) && $past(host_wdata[SRST_POS])));
endmodule

// File: tb/ide_ctl_emu_test.sv
module ide_ctl_emu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       host_rd_alt = 1'b0;
  logic       host_rd_pri = 1'b0;
  logic [0:0] dev_sel = '0;
  logic [7:0] host_rdata;
  logic       host_rvalid;
  logic       host_irq;
  logic       srst_pulse;
  logic [1:0] dev_upd = '0;
  logic [7:0] dev_stat = '0;
  logic [1:0] dev_irq_req = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ide_ctl_emu uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd_alt(host_rd_alt), .host_rd_pri(host_rd_pri), .dev_sel(dev_sel),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_irq(host_irq),
    .srst_pulse(srst_pulse), .dev_upd(dev_upd), .dev_stat(dev_stat),
    .dev_irq_req(dev_irq_req)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wr(input logic [7:0] v);
    host_wr = 1'b1; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic do_rd(input bit pri, input bit sel, input logic [7:0] exp, input string tag);
    dev_sel = sel;
    if (pri) host_rd_pri = 1'b1; else host_rd_alt = 1'b1;
    @(negedge clk);
    host_rd_pri = 1'b0; host_rd_alt = 1'b0;
    chk({tag, " rvalid"}, host_rvalid, 1'b1);
    chk({tag, " rdata"}, host_rdata, exp);
  endtask

  task automatic upd(input int d, input logic [7:0] v);
    dev_upd[d] = 1'b1; dev_stat = v;
    @(negedge clk);
    dev_upd = '0;
  endtask

  task automatic req(input int d);
    dev_irq_req[d] = 1'b1;
    @(negedge clk);
    dev_irq_req = '0;
  endtask

  task automatic irq_on(input bit sel, input logic exp, input string tag);
    dev_sel = sel;
    #1;
    chk(tag, host_irq, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 rdata", host_rdata, 8'h00);
    chk("R1 rvalid", host_rvalid, 1'b0);
    chk("R1 irq", host_irq, 1'b0);
    chk("R1 pulse", srst_pulse, 1'b0);
    do_rd(0, 0, 8'h00, "R1 dev0");
    do_rd(0, 1, 8'h00, "R1 dev1");
    idle(1);
    chk("R3 rvalid single", host_rvalid, 1'b0);

    // R5 / R3 status sweep, complementary bytes per device
    for (int v = 0; v < 256; v++) begin
      upd(0, 8'(v));
      upd(1, ~8'(v));
      do_rd(0, 0, 8'(v), "R5 R3 dev0");
      dev_sel = 1'b0; // select moved after the strobe must not matter
      do_rd(0, 1, ~8'(v), "R5 R3 dev1");
    end
    upd(0, 8'h11);
    upd(1, 8'h22);

    // R6 pending per device
    req(0);
    irq_on(0, 1'b1, "R6 dev0 set");
    irq_on(1, 1'b0, "R6 dev1 clear");
    req(1);
    irq_on(1, 1'b1, "R6 dev1 set");

    // R8 alternate reads keep pending
    for (int i = 0; i < 4; i++) begin
      do_rd(0, 0, 8'h11, "R8 alt read");
      irq_on(0, 1'b1, "R8 pending kept");
    end

    // R4 write and read together: read dropped, write applied
    dev_sel = 1'b0;
    host_wr = 1'b1; host_wdata = 8'h02; host_rd_pri = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_rd_pri = 1'b0;
    chk("R4 rvalid", host_rvalid, 1'b0);
    chk("R4 write applied", host_irq, 1'b0);
    do_wr(8'h00);
    irq_on(0, 1'b1, "R4 no clear");

    // R9 primary read clears only selected
    do_rd(1, 0, 8'h11, "R9 pri read");
    irq_on(0, 1'b0, "R9 dev0 cleared");
    irq_on(1, 1'b1, "R9 dev1 kept");

    // R13 request beats clear
    dev_sel = 1'b0; dev_irq_req[0] = 1'b1; host_rd_pri = 1'b1;
    @(negedge clk);
    dev_irq_req = '0; host_rd_pri = 1'b0;
    chk("R13 rdata", host_rdata, 8'h11);
    irq_on(0, 1'b1, "R13 pending kept");

    // R7 masking retains pending
    do_wr(8'h02);
    irq_on(1, 1'b0, "R7 masked dev1");
    irq_on(0, 1'b0, "R7 masked dev0");
    do_wr(8'h00);
    irq_on(1, 1'b1, "R7 unmasked dev1");

    // R2 reserved bits only
    do_wr(8'hF9);
    chk("R2 pulse", srst_pulse, 1'b0);
    irq_on(0, 1'b1, "R2 irq");
    do_rd(0, 0, 8'h11, "R2 no readback");

    // R10 / R11 / R12 software reset
    do_wr(8'h04);
    chk("R10 pulse high", srst_pulse, 1'b1);
    idle(1);
    chk("R10 pulse low", srst_pulse, 1'b0);
    irq_on(0, 1'b0, "R11 pend0 clear");
    irq_on(1, 1'b0, "R11 pend1 clear");
    do_rd(0, 0, 8'h80, "R11 busy dev0");
    do_rd(0, 1, 8'h80, "R11 busy dev1");
    req(0);
    upd(0, 8'h33);
    irq_on(0, 1'b0, "R11 req ignored");
    do_rd(0, 0, 8'h80, "R11 upd ignored");
    do_wr(8'h04);
    chk("R10 no repeat", srst_pulse, 1'b0);
    do_wr(8'h00);
    idle(1);
    do_rd(0, 0, 8'h00, "R12 dev0 released");
    do_rd(0, 1, 8'h00, "R12 dev1 released");

    // control sweep over all write values
    for (int v = 0; v < 256; v++) begin
      logic [7:0] w;
      w = 8'(v);
      do_wr(8'h00);
      idle(1);
      req(0);
      dev_sel = 1'b0;
      do_wr(w);
      chk("R10 R2 sweep pulse", srst_pulse, w[2]);
      idle(1);
      irq_on(0, !(w[1] | w[2]), "R7 R11 sweep irq");
      do_rd(0, 0, w[2] ? 8'h80 : 8'h00, "R2 R11 sweep status");
    end
    do_wr(8'h00);
    idle(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule